// File: doc/BRIEF.md
# Debug Stall and Exception Redirect

This block holds the processor-control word of a debug port and turns it into two CPU-facing signals: a stall level and a single-cycle system reset request. Software writes a two-bit control word. One bit asks for a stall. The other holds the system in reset. The reset request is released as a pulse only when software clears the held reset bit.

The block also decides, for every exception the CPU raises, whether the debugger takes it. A per-type stop mask selects which of thirteen exception kinds are diverted. A diverted exception is suppressed in the same cycle. It sets a sticky bit in a reason register and stalls the CPU from the next cycle on. An exception that is not selected lets the CPU run on and releases any stall. A debugger-disable input keeps the CPU from being stalled at all, while the stored stall bit still follows the writes.

Top module: `dbg_stall_redirect`

## Requirements
- R1: After the synchronous reset `rst`, `ctl_q`, `reason_q`, `cpu_stall`, `sys_reset_pulse` and `exc_suppress` are all 0.
- R2: A control write (`ctl_wr`) loads `ctl_wdata` into `ctl_q` at the next clock edge. Bit 0 is the stall request and bit 1 is the held reset. While `dbg_disable` is low, `cpu_stall` equals `ctl_q[0]`.
- R3: `sys_reset_pulse` is high for exactly one cycle, in the cycle after a control write that changes bit 1 from 1 to 0. Writes that take bit 1 from 0 to 0, 0 to 1 or 1 to 1 give no pulse.
- R4: While `ctl_q[1]` is 1, `exc_valid` is ignored: `exc_suppress` stays 0, and `reason_q` and `ctl_q[0]` do not change.
- R5: While `dbg_disable` is high, `cpu_stall` is 0. Control writes still update `ctl_q[0]`.
- R6: Exception codes are 0 reset, 1 bus error, 2 data page fault, 3 instruction page fault, 4 tick timer, 5 alignment, 6 illegal instruction, 7 external interrupt, 8 data TLB miss, 9 instruction TLB miss, 10 range, 11 system call and 12 trap. Mask bit k and reason bit k belong to code k. A valid exception with code k < 13 and `stop_mask[k]` = 1 raises `exc_suppress` in the same cycle. At the next edge it sets `reason_q[k]` and `ctl_q[0]`.
- R7: A valid exception with code k < 13 and `stop_mask[k]` = 0 leaves `exc_suppress` low and `reason_q` unchanged. It clears `ctl_q[0]` at the next edge.
- R8: A valid exception with a code of 13 to 15 never stops the CPU. `exc_suppress` stays low, `reason_q` does not change, and `ctl_q[0]` is cleared.
- R9: A reason write (`reason_wr`) clears every `reason_q` bit whose `reason_wdata` bit is 1 (write one to clear). A hardware set of the same bit in the same cycle wins. `reason_q` bits never clear in any other way.
- R10: When a control write and a valid exception meet in the same cycle, the written stall bit is loaded. The reason bit is still set if the exception is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high debug-unit reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 2 | Control word write data (bit 1 held reset, bit 0 stall) |
| ctl_q | output | 2 | Stored control word |
| dbg_disable | input | 1 | Forces the CPU stall output low |
| exc_valid | input | 1 | Exception present this cycle |
| exc_code | input | CODE_W (4) | Exception kind code |
| stop_mask | input | NUM_EXC (13) | Per-kind divert enable |
| exc_suppress | output | 1 | Current exception is taken by the debugger |
| reason_wr | input | 1 | Reason register clear strobe |
| reason_wdata | input | NUM_EXC (13) | Bits to clear in the reason register |
| reason_q | output | NUM_EXC (13) | Sticky divert reason bits |
| cpu_stall | output | 1 | Stall level to the CPU |
| sys_reset_pulse | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that `exc_code` holds a defined value whenever `exc_valid` is high. They also assume that the stop mask and the reason write data are stable over the cycle in which they are sampled. The bench drives every input on the falling clock edge, so each one is steady for a full cycle around the rising edge. It never raises `exc_valid` with an undriven code. The sweep covers all sixteen codes against four mask shapes. Before each exception it sets the stored stall bit to the opposite of the expected result, so that every outcome shows up as a change at the ports.

// File: rtl/dbgsr_pkg.sv
package dbgsr_pkg;

    localparam int EXC_CODE_W = 4;
    localparam int EXC_KINDS  = 13;

    typedef enum logic [EXC_CODE_W-1:0] {
        EXC_RESET   = 4'd0,
        EXC_BUSERR  = 4'd1,
        EXC_DPAGE   = 4'd2,
        EXC_IPAGE   = 4'd3,
        EXC_TICK    = 4'd4,
        EXC_ALIGN   = 4'd5,
        EXC_ILLEGAL = 4'd6,
        EXC_EXTINT  = 4'd7,
        EXC_DTLB    = 4'd8,
        EXC_ITLB    = 4'd9,
        EXC_RANGE   = 4'd10,
        EXC_SYSCALL = 4'd11,
        EXC_TRAP    = 4'd12
    } exc_kind_e;

    // Control word: bit 1 holds the system in reset, bit 0 requests a stall.
    typedef struct packed {
        logic hold_rst;
        logic stall;
    } ctl_word_t;

    // A falling held-reset bit on a write releases the system reset.
    function automatic logic reset_release(input ctl_word_t cur, input ctl_word_t nxt);
        return cur.hold_rst & ~nxt.hold_rst;
    endfunction

endpackage

// File: rtl/dbgsr_exc.sv
module dbgsr_exc #(
    parameter int CODE_W  = dbgsr_pkg::EXC_CODE_W,
    parameter int NUM_EXC = dbgsr_pkg::EXC_KINDS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  logic [CODE_W-1:0]  code,
    input  logic [NUM_EXC-1:0] mask,
    input  logic               hold,
    input  logic               clr_wr,
    input  logic [NUM_EXC-1:0] clr_bits,
    output logic               take,
    output logic               hit,
    output logic [NUM_EXC-1:0] reason
);

    logic [NUM_EXC-1:0] sel;
    logic [NUM_EXC-1:0] set_bits;
    logic [NUM_EXC-1:0] keep_bits;

    // One decoder per known kind; codes past the last kind select nothing.
    for (genvar gi = 0; gi < NUM_EXC; gi++) begin : g_dec
        assign sel[gi] = (code == CODE_W'(gi));
    end

    assign take      = valid & ~hold;
    assign hit       = take & |(sel & mask);
    assign set_bits  = hit ? (sel & mask) : '0;
    assign keep_bits = clr_wr ? (reason & ~clr_bits) : reason;

    always_ff @(posedge clk) begin
        if (rst) begin
            reason <= '0;
        end else begin
            reason <= keep_bits | set_bits;
        end
    end

endmodule

// File: rtl/dbgsr_ctl.sv
module dbgsr_ctl
    import dbgsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  ctl_word_t wdata,
    input  logic      exc_take,
    input  logic      exc_hit,
    output ctl_word_t ctl,
    output logic      rst_pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl       <= '0;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= wr & reset_release(ctl, wdata);
            if (wr) begin
                ctl <= wdata;
            end else if (exc_take) begin
                ctl.stall <= exc_hit;
            end
        end
    end

endmodule

// File: rtl/dbg_stall_redirect.sv
module dbg_stall_redirect
    import dbgsr_pkg::*;
#(
    parameter int CODE_W  = EXC_CODE_W,
    parameter int NUM_EXC = EXC_KINDS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_wr,
    input  logic [1:0]         ctl_wdata,
    output logic [1:0]         ctl_q,
    input  logic               dbg_disable,
    input  logic               exc_valid,
    input  logic [CODE_W-1:0]  exc_code,
    input  logic [NUM_EXC-1:0] stop_mask,
    output logic               exc_suppress,
    input  logic               reason_wr,
    input  logic [NUM_EXC-1:0] reason_wdata,
    output logic [NUM_EXC-1:0] reason_q,
    output logic               cpu_stall,
    output logic               sys_reset_pulse
);

    ctl_word_t ctl;
    logic      take;
    logic      hit;

    dbgsr_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .wr        (ctl_wr),
        .wdata     (ctl_word_t'(ctl_wdata)),
        .exc_take  (take),
        .exc_hit   (hit),
        .ctl       (ctl),
        .rst_pulse (sys_reset_pulse)
    );

    dbgsr_exc #(
        .CODE_W  (CODE_W),
        .NUM_EXC (NUM_EXC)
    ) u_exc (
        .clk      (clk),
        .rst      (rst),
        .valid    (exc_valid),
        .code     (exc_code),
        .mask     (stop_mask),
        .hold     (ctl.hold_rst),
        .clr_wr   (reason_wr),
        .clr_bits (reason_wdata),
        .take     (take),
        .hit      (hit),
        .reason   (reason_q)
    );

    assign ctl_q        = ctl;
    assign exc_suppress = hit;
    assign cpu_stall    = ctl.stall & ~dbg_disable;

endmodule

// File: rtl/dbgsr_chk.sv
module dbgsr_chk #(
    parameter int CODE_W  = 4,
    parameter int NUM_EXC = 13
) (
    input logic               clk,
    input logic               rst,
    input logic               ctl_wr,
    input logic [1:0]         ctl_wdata,
    input logic [1:0]         ctl_q,
    input logic               dbg_disable,
    input logic               exc_valid,
    input logic [CODE_W-1:0]  exc_code,
    input logic [NUM_EXC-1:0] stop_mask,
    input logic               exc_suppress,
    input logic               reason_wr,
    input logic [NUM_EXC-1:0] reason_q,
    input logic               cpu_stall,
    input logic               sys_reset_pulse
);

    localparam logic [NUM_EXC-1:0] ONE = NUM_EXC'(1);

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
        sys_reset_pulse |=> !sys_reset_pulse);

    assert_pulse_cause_R3: assert property (@(posedge clk) disable iff (rst)
        sys_reset_pulse |-> $past(ctl_wr && ctl_q[1] && !ctl_wdata[1]));

    assert_disable_gates_R5: assert property (@(posedge clk) disable iff (rst)
        dbg_disable |-> !cpu_stall);

    assert_hold_no_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && ctl_q[1]) |-> !exc_suppress);

    assert_unknown_no_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && int'(exc_code) >= NUM_EXC) |-> !exc_suppress);

    assert_reason_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && !ctl_q[1] && int'(exc_code) < NUM_EXC
         && |(stop_mask & (ONE << exc_code)))
        |=> |(reason_q & (ONE << $past(exc_code))));

    assert_reason_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (!exc_valid && !reason_wr) |=> $stable(reason_q));

endmodule

bind dbg_stall_redirect dbgsr_chk #(
    .CODE_W  (CODE_W),
    .NUM_EXC (NUM_EXC)
) i_chk (.*);

// File: tb/test_dbg_stall_redirect.sv
module test_dbg_stall_redirect;

    localparam int CODE_W  = 4;
    localparam int NUM_EXC = 13;

    logic               clk = 1'b0;
    logic               rst;
    logic               ctl_wr;
    logic [1:0]         ctl_wdata;
    logic [1:0]         ctl_q;
    logic               dbg_disable;
    logic               exc_valid;
    logic [CODE_W-1:0]  exc_code;
    logic [NUM_EXC-1:0] stop_mask;
    logic               exc_suppress;
    logic               reason_wr;
    logic [NUM_EXC-1:0] reason_wdata;
    logic [NUM_EXC-1:0] reason_q;
    logic               cpu_stall;
    logic               sys_reset_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dbg_stall_redirect i_dbg_stall_redirect (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ctl_wr = 0; ctl_wdata = 0; exc_valid = 0; exc_code = 0;
        reason_wr = 0; reason_wdata = 0;
    endtask

    // Drive on a falling edge; results of the edge in between are read at the next one.
    task automatic ctl_write(input logic [1:0] v);
        @(negedge clk); idle(); ctl_wr = 1; ctl_wdata = v;
        @(negedge clk); idle();
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NUM_EXC-1:0] m;
        logic exp_hit;
        logic [NUM_EXC-1:0] exp_rsn;
        idle(); dbg_disable = 0; stop_mask = 0; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctl_q", 32'(ctl_q), 0);
        chk("R1 reason_q", 32'(reason_q), 0);
        chk("R1 cpu_stall", 32'(cpu_stall), 0);
        chk("R1 pulse", 32'(sys_reset_pulse), 0);
        chk("R1 suppress", 32'(exc_suppress), 0);

        // R2 control write and stall follow
        ctl_write(2'b01);
        chk("R2 ctl_q", 32'(ctl_q), 1);
        chk("R2 cpu_stall", 32'(cpu_stall), 1);
        ctl_write(2'b00);
        chk("R2 cpu_stall low", 32'(cpu_stall), 0);

        // R5 disable gates stall, stored bit still updated
        @(negedge clk); dbg_disable = 1;
        ctl_write(2'b01);
        chk("R5 cpu_stall", 32'(cpu_stall), 0);
        chk("R5 ctl_q stall", 32'(ctl_q[0]), 1);
        dbg_disable = 0; #1;
        chk("R5 released", 32'(cpu_stall), 1);
        ctl_write(2'b00);

        // R3 reset pulse only on 1->0 of held reset
        ctl_write(2'b00);
        chk("R3 0to0", 32'(sys_reset_pulse), 0);
        ctl_write(2'b10);
        chk("R3 0to1", 32'(sys_reset_pulse), 0);
        ctl_write(2'b11);
        chk("R3 1to1", 32'(sys_reset_pulse), 0);

        // R4 exceptions ignored while held in reset
        @(negedge clk); idle(); exc_valid = 1; exc_code = 4'd2; stop_mask = '1; #1;
        chk("R4 suppress", 32'(exc_suppress), 0);
        @(negedge clk); idle();
        chk("R4 reason", 32'(reason_q), 0);
        chk("R4 stall kept", 32'(ctl_q[0]), 1);

        ctl_write(2'b00);
        chk("R3 1to0 pulse", 32'(sys_reset_pulse), 1);
        @(negedge clk);
        chk("R3 pulse one cycle", 32'(sys_reset_pulse), 0);

        // R6/R7/R8 sweep: all codes against four mask shapes
        for (int c = 0; c < 16; c++) begin
            for (int s = 0; s < 4; s++) begin
                case (s)
                    0: m = '1;
                    1: m = '0;
                    2: m = (c < NUM_EXC) ? (NUM_EXC'(1) << c) : '0;
                    default: m = (c < NUM_EXC) ? ~(NUM_EXC'(1) << c) : '1;
                endcase
                exp_hit = (c < NUM_EXC) && m[c % NUM_EXC];
                exp_rsn = exp_hit ? (NUM_EXC'(1) << c) : '0;
                // clear reasons, set stall to the opposite of the expected result
                @(negedge clk); idle(); ctl_wr = 1; ctl_wdata = {1'b0, ~exp_hit};
                reason_wr = 1; reason_wdata = '1;
                @(negedge clk); idle(); exc_valid = 1; exc_code = 4'(c); stop_mask = m; #1;
                if (c >= NUM_EXC) chk("R8 suppress", 32'(exc_suppress), 0);
                else if (exp_hit) chk("R6 suppress", 32'(exc_suppress), 1);
                else chk("R7 suppress", 32'(exc_suppress), 0);
                @(negedge clk); idle();
                if (c >= NUM_EXC) begin
                    chk("R8 reason", 32'(reason_q), 0);
                    chk("R8 stall", 32'(cpu_stall), 0);
                end else if (exp_hit) begin
                    chk("R6 reason", 32'(reason_q), 32'(exp_rsn));
                    chk("R6 stall", 32'(cpu_stall), 1);
                end else begin
                    chk("R7 reason", 32'(reason_q), 0);
                    chk("R7 stall", 32'(cpu_stall), 0);
                end
            end
        end

        // R9 write-one-to-clear; hardware set wins in same cycle
        @(negedge clk); idle(); reason_wr = 1; reason_wdata = '1;
        @(negedge clk); idle(); exc_valid = 1; exc_code = 4'd3; stop_mask = '1;
        @(negedge clk); idle(); exc_valid = 1; exc_code = 4'd9;
        @(negedge clk); idle();
        chk("R9 sticky two", 32'(reason_q), 32'(13'h0208));
        @(negedge clk); idle(); reason_wr = 1; reason_wdata = 13'h0008;
        @(negedge clk); idle();
        chk("R9 clear one", 32'(reason_q), 32'(13'h0200));
        @(negedge clk); idle(); reason_wr = 1; reason_wdata = 13'h0200;
        exc_valid = 1; exc_code = 4'd9;
        @(negedge clk); idle();
        chk("R9 set wins", 32'(reason_q), 32'(13'h0200));

        // R10 control write and exception in the same cycle
        @(negedge clk); idle(); reason_wr = 1; reason_wdata = '1;
        @(negedge clk); idle(); ctl_wr = 1; ctl_wdata = 2'b00;
        exc_valid = 1; exc_code = 4'd12; stop_mask = '1;
        @(negedge clk); idle();
        chk("R10 stall from write", 32'(ctl_q[0]), 0);
        chk("R10 reason set", 32'(reason_q), 32'(13'h1000));

        // R1 reset clears everything again
        ctl_write(2'b11);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk("R1 ctl after reset", 32'(ctl_q), 0);
        chk("R1 reason after reset", 32'(reason_q), 0);
        chk("R1 pulse after reset", 32'(sys_reset_pulse), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule